// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache Controller

This block sits between an instruction fetch stage and a separate bus-master engine. It holds eight lines of four 32-bit words (128 bytes) with one way per set. When the processor fetches an address that hits, the instruction comes back in the same cycle with no stall. When the fetch misses, the controller stalls the processor and records the line address. It then spends one cycle choosing the victim. After that it asks the bus engine for the whole line and collects the returned words one by one in a line buffer. Only when the last word has arrived does it write the line, its tag and its valid bit into the arrays. The fetch is then replayed as a hit.

Fetches that the processor marks as uncached never allocate. They ask the bus engine for a single word, which is handed straight to the processor from the buffer. If the bus engine flags an error response, the controller raises a one-cycle fault indication instead of an instruction. It leaves the arrays untouched and returns to idle.

Top module: `icache_ctrl`

## Requirements
- R1: After reset `fetch_stall`, `fetch_err` and `fill_req` are low with no request, and every line is invalid, so the first cached fetch to any address misses.
- R2: An address is split into a line offset in bits [3:0] (word select in bits [3:2]), a set index in bits [6:4] and a 25-bit tag in bits [31:7]; a hit needs a valid line in the indexed set whose stored tag equals the tag bits, and the byte bits [1:0] do not change the returned word.
- R3: A cached fetch that hits returns the addressed word on `fetch_instr` in the same cycle with `fetch_stall` low, and issues no fill request.
- R4: A cached fetch that misses raises `fetch_stall` in the same cycle. One select cycle follows, and then `fill_req` rises with `fill_unc` low and `fill_addr` equal to the line base (bits [3:0] zero). `fill_req` and `fill_addr` stay steady until a response arrives.
- R5: Line words are accepted on `fill_rvalid` in order, word 0 first. The arrays are written only in the cycle after the fourth word. The stalled fetch then completes as a hit with the requested word.
- R6: An uncached fetch (`fetch_unc` high) raises `fill_req` with `fill_unc` high and a word-aligned `fill_addr`, and takes a single response word. The word is delivered with `fetch_stall` low in the cycle after the response. Nothing is allocated: a later cached fetch of the same line still misses.
- R7: A response with `fill_rerr` high makes `fetch_err` high, with `fetch_stall` low, for exactly one cycle. After that the controller is idle and has written nothing: the line previously held in that set still hits.
- R8: Two lines with the same set index and different tags replace each other, so alternating between them misses every time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Processor fetch request, held while stalled |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_unc | input | 1 | Fetch targets an uncached region |
| fetch_instr | output | 32 | Returned instruction word |
| fetch_stall | output | 1 | Processor must hold its request |
| fetch_err | output | 1 | One-cycle bus fault indication |
| fill_req | output | 1 | Request to the bus engine, held until answered |
| fill_unc | output | 1 | High: single-word read; low: four-word line read |
| fill_addr | output | 32 | Line base or word address for the bus engine |
| fill_rvalid | input | 1 | Bus engine delivers one response word |
| fill_rerr | input | 1 | The delivered response is an error |
| fill_rdata | input | 32 | Response data word |

## Verification
The assertions take for granted that the processor keeps its request, address and uncached flag steady while it is stalled. They also take for granted that the bus engine pulses `fill_rvalid` only while `fill_req` is high, and ends a line read after its first error response. The bench's processor driver changes its inputs only after it sees the stall released. Its bus-engine model answers only a pending `fill_req`, with at most one response per two cycles, and stops sending words as soon as it reports an error. Erroring addresses are limited to one address region, so the expected fault can be computed from the address alone.

// File: rtl/icache_pkg.sv
package icache_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_PICK     = 3'd1,
      ST_FILL     = 3'd2,
      ST_COMMIT   = 3'd3,
      ST_UNC_WAIT = 3'd4,
      ST_UNC_GIVE = 3'd5,
      ST_FAULT    = 3'd6
   } ic_state_e;

endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
   parameter int SETS  = 8,
   parameter int IDX_W = 3,
   parameter int TAG_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_valid,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag
);

   logic [SETS-1:0]  valid_q;
   logic [TAG_W-1:0] tag_q [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[s] <= 1'b0;
            tag_q[s]   <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(s))) begin
            valid_q[s] <= 1'b1;
            tag_q[s]   <= wr_tag;
         end
      end
   end

   assign rd_tag   = tag_q[rd_idx];
   assign rd_valid = valid_q[rd_idx];

   // no set becomes valid without a write to it
   p_valid_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_q[rd_idx]) |-> $past(wr_en));

endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
   parameter int SETS       = 8,
   parameter int IDX_W      = 3,
   parameter int LINE_WORDS = 4,
   parameter int WSEL_W     = 2,
   parameter int WORD_W     = 32
) (
   input  logic                         clk,
   input  logic                         wr_en,
   input  logic [IDX_W-1:0]             wr_idx,
   input  logic [LINE_WORDS*WORD_W-1:0] wr_line,
   input  logic [IDX_W-1:0]             rd_idx,
   input  logic [WSEL_W-1:0]            rd_wsel,
   output logic [WORD_W-1:0]            rd_word
);

   localparam int LINE_W = LINE_WORDS * WORD_W;

   logic [LINE_W-1:0] line_q [SETS];
   logic [LINE_W-1:0] sel_line;

   always_ff @(posedge clk) begin
      if (wr_en) line_q[wr_idx] <= wr_line;
   end

   assign sel_line = line_q[rd_idx];
   assign rd_word  = sel_line[rd_wsel*WORD_W +: WORD_W];

endmodule

// File: rtl/icache_line_buf.sv
module icache_line_buf #(
   parameter int LINE_WORDS = 4,
   parameter int WSEL_W     = 2,
   parameter int WORD_W     = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic                         push,
   input  logic [WORD_W-1:0]            push_data,
   output logic [LINE_WORDS*WORD_W-1:0] line,
   output logic                         last
);

   logic [WSEL_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt_q <= '0;
      else if (push)       cnt_q <= cnt_q + 1'b1;
   end

   for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                              word_q <= '0;
         else if (push && (cnt_q == WSEL_W'(w))) word_q <= push_data;
      end
      assign line[w*WORD_W +: WORD_W] = word_q;
   end

   assign last = (cnt_q == WSEL_W'(LINE_WORDS - 1));

   // words land in order: the slot counter advances by one per accepted word
   p_in_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clear) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl #(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int SETS       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_unc,
   output logic [WORD_W-1:0] fetch_instr,
   output logic              fetch_stall,
   output logic              fetch_err,
   output logic              fill_req,
   output logic              fill_unc,
   output logic [ADDR_W-1:0] fill_addr,
   input  logic              fill_rvalid,
   input  logic              fill_rerr,
   input  logic [WORD_W-1:0] fill_rdata
);
   import icache_pkg::*;

   localparam int BYTES_W = WORD_W / 8;
   localparam int BSEL_W  = $clog2(BYTES_W);
   localparam int WSEL_W  = $clog2(LINE_WORDS);
   localparam int OFS_W   = BSEL_W + WSEL_W;
   localparam int IDX_W   = $clog2(SETS);
   localparam int TAG_W   = ADDR_W - IDX_W - OFS_W;

   if ((WORD_W % 8) != 0 || (1 << BSEL_W) != BYTES_W) begin : g_bad_word
      $error("WORD_W must be a power-of-two number of bytes");
   end
   if ((1 << WSEL_W) != LINE_WORDS || LINE_WORDS < 2) begin : g_bad_line
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if ((1 << IDX_W) != SETS || SETS < 2) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the geometry");
   end

   ic_state_e         state_q, state_d;
   logic [ADDR_W-1:0] lat_addr_q;

   logic [IDX_W-1:0]  req_idx, lat_idx;
   logic [TAG_W-1:0]  req_tag, lat_tag;
   logic [WSEL_W-1:0] req_wsel;
   logic [TAG_W-1:0]  rd_tag;
   logic              rd_valid, hit;
   logic [WORD_W-1:0] rd_word;
   logic [LINE_WORDS*WORD_W-1:0] buf_line;
   logic              buf_last, buf_push, buf_clear, arr_we;
   logic              take_miss, take_unc;

   assign req_idx  = fetch_addr[OFS_W +: IDX_W];
   assign req_tag  = fetch_addr[ADDR_W-1 -: TAG_W];
   assign req_wsel = fetch_addr[BSEL_W +: WSEL_W];
   assign lat_idx  = lat_addr_q[OFS_W +: IDX_W];
   assign lat_tag  = lat_addr_q[ADDR_W-1 -: TAG_W];

   icache_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (req_idx),
      .rd_tag  (rd_tag),
      .rd_valid(rd_valid),
      .wr_en   (arr_we),
      .wr_idx  (lat_idx),
      .wr_tag  (lat_tag)
   );

   icache_data_store #(.SETS(SETS), .IDX_W(IDX_W), .LINE_WORDS(LINE_WORDS),
                       .WSEL_W(WSEL_W), .WORD_W(WORD_W)) u_data (
      .clk    (clk),
      .wr_en  (arr_we),
      .wr_idx (lat_idx),
      .wr_line(buf_line),
      .rd_idx (req_idx),
      .rd_wsel(req_wsel),
      .rd_word(rd_word)
   );

   icache_line_buf #(.LINE_WORDS(LINE_WORDS), .WSEL_W(WSEL_W), .WORD_W(WORD_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (buf_clear),
      .push     (buf_push),
      .push_data(fill_rdata),
      .line     (buf_line),
      .last     (buf_last)
   );

   assign hit       = rd_valid && (rd_tag == req_tag);
   assign take_unc  = fetch_req && fetch_unc;
   assign take_miss = fetch_req && !fetch_unc && !hit;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (take_unc)       state_d = ST_UNC_WAIT;
            else if (take_miss) state_d = ST_PICK;
         end
         ST_PICK:   state_d = ST_FILL;
         ST_FILL: begin
            if (fill_rvalid && fill_rerr)      state_d = ST_FAULT;
            else if (fill_rvalid && buf_last)  state_d = ST_COMMIT;
         end
         ST_COMMIT: state_d = ST_IDLE;
         ST_UNC_WAIT: begin
            if (fill_rvalid) state_d = fill_rerr ? ST_FAULT : ST_UNC_GIVE;
         end
         ST_UNC_GIVE: state_d = ST_IDLE;
         ST_FAULT:    state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         lat_addr_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && (take_unc || take_miss)) lat_addr_q <= fetch_addr;
      end
   end

   assign buf_clear = (state_q == ST_IDLE);
   assign buf_push  = (state_q == ST_FILL || state_q == ST_UNC_WAIT) &&
                      fill_rvalid && !fill_rerr;
   assign arr_we    = (state_q == ST_COMMIT);

   assign fill_req  = (state_q == ST_FILL) || (state_q == ST_UNC_WAIT);
   assign fill_unc  = (state_q == ST_UNC_WAIT);
   assign fill_addr = fill_unc ? {lat_addr_q[ADDR_W-1:BSEL_W], {BSEL_W{1'b0}}}
                               : {lat_addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

   always_comb begin
      unique case (state_q)
         ST_IDLE:     fetch_stall = take_unc || take_miss;
         ST_UNC_GIVE: fetch_stall = 1'b0;
         ST_FAULT:    fetch_stall = 1'b0;
         default:     fetch_stall = 1'b1;
      endcase
   end

   assign fetch_err   = (state_q == ST_FAULT);
   assign fetch_instr = (state_q == ST_UNC_GIVE) ? buf_line[WORD_W-1:0] :
                        (state_q == ST_FAULT)    ? '0 : rd_word;

   // a cached request that misses in idle must stall at once
   p_miss_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && fetch_req && !fetch_unc && !hit) |-> fetch_stall);

   // the select state lasts one cycle and leads into the line fill
   p_pick_then_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PICK) |=> (fill_req && !fill_unc));

   // an unanswered fill request keeps its address steady
   p_fill_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !fill_rvalid) |=> (fill_req && $stable(fill_addr)));

   // arrays are written only right after the final good line word
   p_commit_after_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> $past(state_q == ST_FILL && fill_rvalid && !fill_rerr));

   // uncached word is handed over one cycle after its response
   p_unc_give_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && fill_unc && fill_rvalid && !fill_rerr) |=> (!fetch_stall && !arr_we));

   // fault lasts a single cycle and writes nothing
   p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_err |=> (!fetch_err && !arr_we));

endmodule

// File: tb/icache_ctrl_test.sv
module icache_ctrl_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_req = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        fetch_unc = 1'b0;
   logic [31:0] fetch_instr;
   logic        fetch_stall, fetch_err;
   logic        fill_req, fill_unc;
   logic [31:0] fill_addr;
   logic        fill_rvalid = 1'b0;
   logic        fill_rerr = 1'b0;
   logic [31:0] fill_rdata = '0;

   int checks = 0;
   int errors = 0;
   int fills  = 0;
   logic [31:0] exp_fill_addr = '0;
   logic        exp_fill_unc = 1'b0;
   logic [32:0] exp_q [$];
   string       tag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   icache_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_unc(fetch_unc),
      .fetch_instr(fetch_instr), .fetch_stall(fetch_stall), .fetch_err(fetch_err),
      .fill_req(fill_req), .fill_unc(fill_unc), .fill_addr(fill_addr),
      .fill_rvalid(fill_rvalid), .fill_rerr(fill_rerr), .fill_rdata(fill_rdata)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
   endfunction

   function automatic logic bad_addr(input logic [31:0] a);
      return a[31:28] == 4'hF;
   endfunction

   task automatic check(input logic ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // bus engine model
   initial begin
      forever begin
         @(negedge clk);
         if (fill_req) begin
            logic [31:0] base;
            int n;
            base = fill_addr;
            n = fill_unc ? 1 : 4;
            fills++;
            check(fill_addr == exp_fill_addr, "R4/R6 fill address", fill_addr, exp_fill_addr);
            check(fill_unc == exp_fill_unc, "R4/R6 fill kind", 32'(fill_unc), 32'(exp_fill_unc));
            for (int i = 0; i < n; i++) begin
               @(posedge clk); #1;
               fill_rvalid = 1'b1;
               fill_rerr   = bad_addr(base);
               fill_rdata  = bad_addr(base) ? 32'hDEAD_BEEF : mem_word(base + 32'(4*i));
               @(posedge clk); #1;
               fill_rvalid = 1'b0;
               fill_rerr   = 1'b0;
               if (bad_addr(base)) break;
            end
         end
      end
   end

   // monitor: pops one expected item per completed fetch
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && fetch_req && !fetch_stall) begin
            logic [32:0] e;
            string t;
            if (exp_q.size() == 0) begin
               check(1'b0, "unexpected completion", fetch_instr, '0);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(fetch_err == e[32], {t, " error flag"}, 32'(fetch_err), 32'(e[32]));
               if (!e[32]) check(fetch_instr == e[31:0], {t, " data"}, fetch_instr, e[31:0]);
            end
         end
      end
   end

   task automatic fetch(input logic [31:0] a, input logic unc, input int exp_fills,
                        input string req);
      int f0, stalls;
      f0 = fills;
      stalls = 0;
      exp_fill_unc  = unc;
      exp_fill_addr = unc ? {a[31:2], 2'b00} : {a[31:4], 4'b0000};
      exp_q.push_back({bad_addr(a), mem_word({a[31:2], 2'b00})});
      tag_q.push_back(req);
      fetch_req  = 1'b1;
      fetch_addr = a;
      fetch_unc  = unc;
      forever begin
         @(negedge clk);
         if (!fetch_stall) break;
         stalls++;
      end
      check(fills - f0 == exp_fills, {req, " fill count"}, 32'(fills - f0), 32'(exp_fills));
      if (exp_fills == 0 && !unc)
         check(stalls == 0, {req, " hit stall cycles"}, 32'(stalls), 32'd0);
      @(posedge clk); #1;
      fetch_req = 1'b0;
      fetch_unc = 1'b0;
   endtask

   task automatic do_reset();
      fetch_req = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!fetch_stall && !fetch_err && !fill_req, "R1 idle outputs after reset",
            {29'd0, fetch_stall, fetch_err, fill_req}, 32'd0);
   endtask

   initial begin
      do_reset();
      // R1: empty cache, R4/R5 line fill then hit
      fetch(32'h0040_0000, 1'b0, 1, "R1 first fetch misses");
      fetch(32'h0040_0004, 1'b0, 0, "R3 hit word1");
      fetch(32'h0040_000C, 1'b0, 0, "R5 hit word3 of filled line");
      fetch(32'h0040_0012, 1'b0, 1, "R2 set1 miss");
      fetch(32'h0040_001B, 1'b0, 0, "R2 byte bits ignored");
      // R8 conflict in set 0
      fetch(32'h0040_0080, 1'b0, 1, "R8 conflict evicts");
      fetch(32'h0040_0000, 1'b0, 1, "R8 original line refetched");
      fetch(32'h0040_0084, 1'b0, 1, "R8 alternate again");
      // R6 uncached never allocates
      fetch(32'h0050_0024, 1'b1, 1, "R6 uncached word");
      fetch(32'h0050_0024, 1'b0, 1, "R6 no allocation");
      fetch(32'h0050_0028, 1'b0, 0, "R6 cached line now hits");
      // R7 errors
      fetch(32'h0040_0040, 1'b0, 1, "R7 preload set4");
      fetch(32'hF000_0044, 1'b0, 1, "R7 errored line fill");
      fetch(32'h0040_0048, 1'b0, 0, "R7 set4 untouched");
      fetch(32'hF000_0100, 1'b1, 1, "R7 errored uncached");
      fetch(32'h0040_0010, 1'b0, 0, "R3 hit after fault");
      // R1: reset invalidates
      do_reset();
      fetch(32'h0040_0010, 1'b0, 1, "R1 reset invalidated line");
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R5 all fetches completed", 32'(exp_q.size()), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule